// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block sits beside the fetch and decode logic of a small 8-bit processor core. It owns the global interrupt enable flag and the stack pointer, and it decides at which instruction boundary a pending interrupt request is taken. Once a request is taken, it runs a fixed, cycle-exact entry sequence. It stalls fetch, writes the resume address to a byte-wide stack one byte per cycle, clears the enable flag and hands the core a vector address. A return instruction starts the mirror sequence. The block reads the two address bytes back, raises the stack pointer by two, gives the resume address to the core and sets the enable flag again.

The core reports each completed instruction with a boundary strobe. Together with the strobe it gives decoded flags for the enable, disable and return instructions and the address at which execution would continue. Requests arrive as a level vector, and the lowest index has the highest priority. A request stays pending until this block acknowledges it. When the core is asleep, an external signal marks the end of the oscillator start-up delay. An interrupt taken on that signal spends four extra cycles before the normal entry sequence.

The stack memory is outside the block. It is reached through a plain write port and a read port with one cycle of read latency, so it maps onto block RAM.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the enable flag is 0, busy is 0, the stack pointer equals SP_INIT, and ack, vec_valid, ret_valid and mem_we are all 0.
- R2: A request is taken only in a cycle where boundary is 1, the enable flag is 1, busy is 0, at least one request bit is set, asleep is 0, and none of op_sei, op_cli, op_reti is set. The lowest set index i wins. The cycle after acceptance, ack carries a single-cycle one-hot pulse with bit i set. vec_addr equals VEC_BASE + 2*i.
- R3: After acceptance at cycle t, busy is 1 in cycles t+1 to t+4 and 0 at t+5. vec_valid is 1 only in cycle t+4. The enable flag reads 0 from cycle t+1.
- R4: In the first entry cycle, resume address bits [7:0] are written at the stack pointer. In the second entry cycle, bits [15:8] are written at stack pointer minus 1. The stack pointer ends 2 lower, and no other entry cycle writes.
- R5: While asleep is 1, a wake_done pulse with the enable flag at 1 and a request pending takes the request. Busy then lasts 8 cycles, the two writes fall in cycles 5 and 6, vec_valid falls in cycle 8, and ack falls in cycle 1. A wake_done pulse with the enable flag at 0 takes nothing.
- R6: op_reti at a boundary at cycle t makes busy 1 in cycles t+1 to t+4. Reads go to SP+1 in cycle t+1 and to SP+2 in cycle t+2, where SP is the pointer at cycle t. In cycle t+4, ret_valid is 1 and ret_pc is {byte at SP+1, byte at SP+2}. The stack pointer ends 2 higher, and the enable flag is 1 from cycle t+5.
- R7: op_sei at a boundary sets the enable flag from the next cycle. No request is taken at that boundary or at the next boundary, even if the next instruction is the sleep instruction.
- R8: op_cli at a boundary blocks acceptance at that same boundary and clears the enable flag from the next cycle.
- R9: Boundary strobes and decoded instruction flags that arrive while busy is 1 change nothing. In particular, op_sei during entry leaves the enable flag at 0.
- R10: A request that is pending between boundaries, while boundary is 0, is not taken until the next boundary strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | An instruction completes this cycle |
| op_sei | input | 1 | The completing instruction enables interrupts |
| op_cli | input | 1 | The completing instruction disables interrupts |
| op_reti | input | 1 | The completing instruction returns from interrupt |
| pc_next | input | 16 | Address at which execution would continue |
| asleep | input | 1 | The core is in a sleep mode |
| wake_done | input | 1 | Start-up delay after wakeup has elapsed (pulse) |
| req | input | N_REQ | Pending request levels, index 0 highest priority |
| ack | output | N_REQ | One-hot acknowledge pulse for the taken request |
| gie | output | 1 | Global interrupt enable flag |
| busy | output | 1 | Entry or return sequence running; stalls fetch |
| sp | output | SP_W | Stack pointer |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | SP_W | Stack address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, one cycle after mem_addr |
| vec_valid | output | 1 | Vector address ready; fetch may start next cycle |
| vec_addr | output | 16 | Vector address of the taken request |
| ret_valid | output | 1 | Resume address ready after return |
| ret_pc | output | 16 | Resume address popped from the stack |

## Verification
The bench aims at the acceptance gating around the enable and disable instructions. A design that ignores the grace period takes the pending request one instruction early, and one that lets a disable instruction act late takes a request at the disable boundary. Both show up as an early ack and busy. Several requests are raised together, and requests are also raised between boundaries, to catch a wrong priority order or acceptance without a strobe. The sleep path checks the four extra cycles and a wakeup with the flag clear. A return issued straight after reset checks pop order and stack pointer wraparound against known memory contents. Any slip in push order or read latency shows up as a swapped or stale ret_pc.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int PC_W   = 16;
  localparam int BYTE_W = 8;
  localparam int STEPS  = 4;
  localparam int CNT_W  = $clog2(STEPS);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAKE  = 2'd1,
    PH_ENTRY = 2'd2,
    PH_RET   = 2'd3
  } phase_t;
endpackage

// File: rtl/isq_pick.sv
module isq_pick #(
  parameter int N_REQ = 8,
  localparam int IW   = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  logic [N_REQ:0]   below;
  logic [N_REQ-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N_REQ; i++) begin : g_chain
    assign below[i+1] = below[i] | req[i];
    assign grant[i]   = req[i] & ~below[i];
  end
  assign any = below[N_REQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/isq_gate.sv
module isq_gate (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic op_sei,
  input  logic op_cli,
  input  logic op_reti,
  input  logic asleep,
  input  logic wake_done,
  input  logic any_req,
  input  logic busy,
  input  logic ret_done,
  output logic gie,
  output logic acc_b,
  output logic acc_w,
  output logic start_ret
);
  logic gie_q;
  logic grace_q;
  logic live_bnd;

  assign live_bnd = boundary && !busy;

  always_comb begin
    acc_b     = live_bnd && gie_q && !grace_q && !op_cli && !op_sei &&
                !op_reti && !asleep && any_req;
    acc_w     = !busy && asleep && wake_done && gie_q && any_req;
    start_ret = live_bnd && op_reti && !asleep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      grace_q <= 1'b0;
    end else begin
      if (acc_b || acc_w)  gie_q <= 1'b0;
      else if (ret_done)   gie_q <= 1'b1;
      else if (live_bnd) begin
        if (op_cli)        gie_q <= 1'b0;
        else if (op_sei)   gie_q <= 1'b1;
      end
      if (live_bnd) grace_q <= op_sei && !op_cli;
    end
  end

  assign gie = gie_q;

  AST_GRACE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (live_bnd && op_sei) |=> !acc_b);  // R7
endmodule

// File: rtl/isq_core.sv
module isq_core
  import isq_pkg::*;
#(
  parameter int N_REQ              = 8,
  parameter int SP_W               = 8,
  parameter logic [SP_W-1:0] SP_INIT  = '1,
  parameter logic [PC_W-1:0] VEC_BASE = 16'h0002,
  localparam int IW                = $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_b,
  input  logic              acc_w,
  input  logic              start_ret,
  input  logic [IW-1:0]     pick_idx,
  input  logic [PC_W-1:0]   pc_next,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic [SP_W-1:0]   sp,
  output logic [N_REQ-1:0]  ack,
  output logic              mem_we,
  output logic [SP_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              vec_valid,
  output logic [PC_W-1:0]   vec_addr,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_pc
);
  localparam logic [SP_W-1:0]  SP_ONE  = 1;
  localparam logic [SP_W-1:0]  SP_TWO  = 2;
  localparam logic [N_REQ-1:0] BIT0    = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(STEPS - 1);

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [PC_W-1:0]     pc_q;
  logic [PC_W-1:0]     vec_q;
  logic [PC_W-1:0]     ret_q;
  logic [BYTE_W-1:0]   hi_q;
  logic [SP_W-1:0]     sp_q;
  logic [N_REQ-1:0]    ack_q;
  logic                last;

  assign last = (cnt_q == CNT_LST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pc_q    <= '0;
      vec_q   <= '0;
      ret_q   <= '0;
      hi_q    <= '0;
      sp_q    <= SP_INIT;
      ack_q   <= '0;
    end else begin
      ack_q <= '0;
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (acc_b || acc_w) begin
            phase_q <= acc_w ? PH_WAKE : PH_ENTRY;
            pc_q    <= pc_next;
            vec_q   <= VEC_BASE + (PC_W'(pick_idx) << 1);
            ack_q   <= BIT0 << pick_idx;
          end else if (start_ret) begin
            phase_q <= PH_RET;
          end
        end
        PH_WAKE: begin
          cnt_q <= cnt_q + CNT_ONE;
          if (last) phase_q <= PH_ENTRY;
        end
        PH_ENTRY: begin
          cnt_q <= cnt_q + CNT_ONE;
          if (!cnt_q[1]) sp_q <= sp_q - SP_ONE;
          if (last) phase_q <= PH_IDLE;
        end
        PH_RET: begin
          cnt_q <= cnt_q + CNT_ONE;
          if (!cnt_q[1]) sp_q <= sp_q + SP_ONE;
          if (cnt_q == CNT_W'(1)) hi_q <= mem_rdata;
          if (cnt_q == CNT_W'(2)) ret_q <= {hi_q, mem_rdata};
          if (last) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (phase_q != PH_IDLE);
    mem_we    = (phase_q == PH_ENTRY) && !cnt_q[1];
    mem_addr  = (phase_q == PH_RET) ? sp_q + SP_ONE : sp_q;
    mem_wdata = cnt_q[0] ? pc_q[15:8] : pc_q[7:0];
    vec_valid = (phase_q == PH_ENTRY) && last;
    ret_valid = (phase_q == PH_RET) && last;
  end

  assign sp       = sp_q;
  assign ack      = ack_q;
  assign vec_addr = vec_q;
  assign ret_pc   = ret_q;

  AST_PUSH_DOWNWARD: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_ONE));  // R4
  AST_VEC_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(mem_we, 3) && $past(mem_we, 2) && !$past(mem_we, 1)));  // R3
  AST_POP_RAISES_SP: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (sp_q == $past(sp_q, 3) + SP_TWO));  // R6
  AST_NO_WRITE_IN_RET: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !$past(mem_we));  // R6
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import isq_pkg::*;
#(
  parameter int N_REQ              = 8,
  parameter int SP_W               = 8,
  parameter logic [SP_W-1:0] SP_INIT  = '1,
  parameter logic [15:0]     VEC_BASE = 16'h0002
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             op_sei,
  input  logic             op_cli,
  input  logic             op_reti,
  input  logic [15:0]      pc_next,
  input  logic             asleep,
  input  logic             wake_done,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] ack,
  output logic             gie,
  output logic             busy,
  output logic [SP_W-1:0]  sp,
  output logic             mem_we,
  output logic [SP_W-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             vec_valid,
  output logic [15:0]      vec_addr,
  output logic             ret_valid,
  output logic [15:0]      ret_pc
);
  localparam int IW = $clog2(N_REQ);

  logic          any_req;
  logic [IW-1:0] pick_idx;
  logic          acc_b;
  logic          acc_w;
  logic          start_ret;

  isq_pick #(.N_REQ(N_REQ)) u_pick (
    .req (req),
    .any (any_req),
    .idx (pick_idx)
  );

  isq_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .op_sei    (op_sei),
    .op_cli    (op_cli),
    .op_reti   (op_reti),
    .asleep    (asleep),
    .wake_done (wake_done),
    .any_req   (any_req),
    .busy      (busy),
    .ret_done  (ret_valid),
    .gie       (gie),
    .acc_b     (acc_b),
    .acc_w     (acc_w),
    .start_ret (start_ret)
  );

  isq_core #(
    .N_REQ    (N_REQ),
    .SP_W     (SP_W),
    .SP_INIT  (SP_INIT),
    .VEC_BASE (VEC_BASE)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .acc_b     (acc_b),
    .acc_w     (acc_w),
    .start_ret (start_ret),
    .pick_idx  (pick_idx),
    .pc_next   (pc_next),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .sp        (sp),
    .ack       (ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .ret_valid (ret_valid),
    .ret_pc    (ret_pc)
  );

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));  // R2
  AST_ACK_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> (!gie && busy));  // R3
  AST_FLAG_AFTER_RET: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> (gie && !busy));  // R6
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (|ack) |-> $past(|req));  // R2
endmodule

// File: tb/sim_irq_sequencer.sv
`timescale 1ns/1ps
module sim_irq_sequencer;
  localparam int N_REQ = 8;
  localparam int SP_W  = 8;
  localparam int SP_INIT = 255;
  localparam int VBASE = 2;
  localparam int MASK  = (1 << SP_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary = 0, op_sei = 0, op_cli = 0, op_reti = 0, asleep = 0, wake_done = 0;
  logic [15:0] pc_next = '0;
  logic [N_REQ-1:0] req = '0;
  logic [N_REQ-1:0] ack;
  logic gie, busy, mem_we, vec_valid, ret_valid;
  logic [SP_W-1:0] sp, mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [15:0] vec_addr, ret_pc;

  always #4 clk = ~clk;

  irq_sequencer #(.N_REQ(N_REQ), .SP_W(SP_W), .SP_INIT(8'hFF), .VEC_BASE(16'h0002)) u0 (
    .clk(clk), .rst(rst), .boundary(boundary), .op_sei(op_sei), .op_cli(op_cli),
    .op_reti(op_reti), .pc_next(pc_next), .asleep(asleep), .wake_done(wake_done),
    .req(req), .ack(ack), .gie(gie), .busy(busy), .sp(sp), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  logic [7:0] env_mem [0:MASK];
  int model_mem [0:MASK];

  always @(posedge clk) begin
    mem_rdata <= env_mem[mem_addr];
    if (mem_we) env_mem[mem_addr] <= mem_wdata;
  end

  typedef struct {
    bit busy; bit we; int addr; int wdata; bit chk_addr; int ack;
    bit vec; int vaddr; bit ret; int rpc; int sp; bit set_gie; int grp;
  } rec_t;

  rec_t q[$];
  rec_t cur;
  int gie_m = 0;
  int grace_m = 0;
  int sp_m = SP_INIT;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  function automatic rec_t idle_rec(int s);
    rec_t r;
    r = '{default: 0};
    r.sp = s;
    return r;
  endfunction

  function automatic rec_t busy_rec(int s, int grp);
    rec_t r;
    r = idle_rec(s);
    r.busy = 1;
    r.grp = grp;
    return r;
  endfunction

  function automatic int low_idx(logic [N_REQ-1:0] v);
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (v[i]) low_idx = i;
    end
  endfunction

  function automatic void plan_entry(int pc, int idx, bit slept);
    rec_t r;
    int s0;
    s0 = sp_m;
    if (slept) begin
      for (int k = 0; k < 4; k++) begin
        r = busy_rec(s0, 2);
        if (k == 0) r.ack = 1 << idx;
        q.push_back(r);
      end
    end
    r = busy_rec(s0, 1); r.we = 1; r.addr = s0; r.wdata = pc & 255;
    if (!slept) r.ack = 1 << idx;
    q.push_back(r);
    r = busy_rec((s0 - 1) & MASK, 1); r.we = 1; r.addr = (s0 - 1) & MASK; r.wdata = (pc >> 8) & 255;
    q.push_back(r);
    r = busy_rec((s0 - 2) & MASK, 1);
    q.push_back(r);
    r = busy_rec((s0 - 2) & MASK, 1); r.vec = 1; r.vaddr = VBASE + 2 * idx;
    q.push_back(r);
    model_mem[s0] = pc & 255;
    model_mem[(s0 - 1) & MASK] = (pc >> 8) & 255;
    sp_m = (s0 - 2) & MASK;
  endfunction

  function automatic void plan_return();
    rec_t r;
    int s0;
    s0 = sp_m;
    r = busy_rec(s0, 3); r.chk_addr = 1; r.addr = (s0 + 1) & MASK; q.push_back(r);
    r = busy_rec((s0 + 1) & MASK, 3); r.chk_addr = 1; r.addr = (s0 + 2) & MASK; q.push_back(r);
    r = busy_rec((s0 + 2) & MASK, 3); q.push_back(r);
    r = busy_rec((s0 + 2) & MASK, 3); r.ret = 1; r.set_gie = 1;
    r.rpc = (model_mem[(s0 + 1) & MASK] << 8) | model_mem[(s0 + 2) & MASK];
    q.push_back(r);
    sp_m = (s0 + 2) & MASK;
  endfunction

  task automatic chk(string what, int act, int exp, int grp);
    string t;
    n_chk++;
    case (grp)
      1: t = "R3/R4";
      2: t = "R5";
      3: t = "R6";
      default: t = tag;
    endcase
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("busy", int'(busy), int'(cur.busy), cur.grp);
    chk("mem_we", int'(mem_we), int'(cur.we), cur.grp);
    chk("sp", int'(sp), cur.sp, cur.grp);
    chk("ack", int'(ack), cur.ack, cur.grp);
    chk("vec_valid", int'(vec_valid), int'(cur.vec), cur.grp);
    chk("ret_valid", int'(ret_valid), int'(cur.ret), cur.grp);
    chk("gie", int'(gie), gie_m, cur.grp);
    if (cur.we) begin
      chk("push addr", int'(mem_addr), cur.addr, cur.grp);
      chk("push data", int'(mem_wdata), cur.wdata, cur.grp);
    end
    if (cur.chk_addr) chk("pop addr", int'(mem_addr), cur.addr, cur.grp);
    if (cur.vec) chk("vec_addr", int'(vec_addr), cur.vaddr, cur.grp);
    if (cur.ret) chk("ret_pc", int'(ret_pc), cur.rpc, cur.grp);
  endtask

  task automatic step(bit bnd, bit sei, bit cli, bit reti, bit slp, bit wk, int pc);
    bit is_busy, acc_b, acc_w, do_ret;
    boundary = bnd; op_sei = sei; op_cli = cli; op_reti = reti;
    asleep = slp; wake_done = wk; pc_next = 16'(pc);
    is_busy = cur.busy;
    acc_b  = !is_busy && bnd && gie_m != 0 && grace_m == 0 && !cli && !sei && !reti && !slp && req != 0;
    acc_w  = !is_busy && slp && wk && gie_m != 0 && req != 0;
    do_ret = !is_busy && bnd && reti && !slp;
    if (cur.set_gie) gie_m = 1;
    else if (acc_b || acc_w) gie_m = 0;
    else if (bnd && !is_busy) begin
      if (cli) gie_m = 0;
      else if (sei) gie_m = 1;
    end
    if (bnd && !is_busy) grace_m = (sei && !cli) ? 1 : 0;
    if (acc_b || acc_w) plan_entry(pc, low_idx(req), acc_w);
    else if (do_ret) plan_return();
    if (q.size() > 0) cur = q.pop_front();
    else cur = idle_rec(sp_m);
    @(posedge clk);
    @(negedge clk);
    compare();
    if (cur.ack != 0) req = req & ~N_REQ'(cur.ack);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bnd(int pc);
    step(1, 0, 0, 0, 0, 0, pc);
  endtask

  initial begin
    for (int i = 0; i <= MASK; i++) begin
      env_mem[i] = 8'((i * 7 + 3) & 255);
      model_mem[i] = (i * 7 + 3) & 255;
    end
    cur = idle_rec(SP_INIT);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    compare();

    tag = "R6";
    step(1, 0, 0, 1, 0, 0, 16'h0100);
    idle(5);

    tag = "R8";
    step(1, 0, 1, 0, 0, 0, 16'h0200);
    tag = "R2";
    req = 8'b0000_0100;
    bnd(16'h0300); bnd(16'h0301); bnd(16'h0302);

    tag = "R7";
    step(1, 1, 0, 0, 0, 0, 16'h1000);
    bnd(16'h1001);
    bnd(16'h1234);
    tag = "R9";
    step(1, 1, 0, 0, 0, 0, 16'h1235);
    step(1, 0, 0, 0, 0, 0, 16'h1236);
    idle(4);

    tag = "R6";
    step(1, 0, 0, 1, 0, 0, 16'h0000);
    idle(6);

    tag = "R2";
    req = 8'b1010_0010;
    bnd(16'h4567);
    idle(6);
    step(1, 0, 0, 1, 0, 0, 0);
    idle(6);
    bnd(16'h89AB);
    idle(6);
    step(1, 0, 0, 1, 0, 0, 0);
    idle(6);
    bnd(16'hCDEF);
    idle(6);
    step(1, 0, 0, 1, 0, 0, 0);
    idle(6);

    tag = "R10";
    req = 8'b0000_0001;
    idle(5);
    bnd(16'hBEEF);
    idle(6);
    step(1, 0, 0, 1, 0, 0, 0);
    idle(6);

    tag = "R8";
    req = 8'b0000_1000;
    step(1, 0, 1, 0, 0, 0, 16'h2000);
    bnd(16'h2001);

    tag = "R9";
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1, 16'h2002);
    idle(3);

    tag = "R7";
    step(1, 1, 0, 0, 0, 0, 16'h3000);
    bnd(16'h3001);
    tag = "R5";
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1, 16'h3002);
    idle(10);
    step(1, 0, 0, 1, 0, 0, 0);
    idle(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule